// File: doc/BRIEF.md
# Dual Down-Counter Timer with Shared Interrupt

This block holds two down-counting timers and one free-running time counter behind a 32-bit register bus that only takes whole words. Each timer has a reload value and a control word. The control word gives an operation (load, hold or run) and picks which tick enable drives the counter. Tick sources arrive as single-cycle enable pulses on input pins, so the whole block runs in one clock domain.

When a running timer reaches zero and sees one more tick, it reloads from its reload value and sets its own bit in a raw interrupt status register. Status bits stay set until software writes a one to the matching bit of an acknowledge location. A mask register selects which status bits can drive the single level-sensitive interrupt output.

Sub-word accesses and control writes that carry the illegal operation code are flagged on an error output and otherwise ignored.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, each timer's control reads 0x1 (hold, source 0) and its count reads 0. The mask, raw status, masked status and time registers all read 0, and `irq` is low.
- R2: Byte addresses decode as follows:
  - timer i (i = 0, 1) reload at 0x10*i+0x0, count at 0x10*i+0x4, control at 0x10*i+0x8
  - time at 0x38, mask at 0x48, acknowledge at 0x4C, raw status at 0x50, masked status at 0x54
  - control reads back {src[4:2], op[1:0]}
  - the acknowledge location and unmapped offsets read 0
- R3: A control write with op=0 (load) copies the reload value into the count and leaves the timer stopped. A reload write alone does not change the count.
- R4: With op=2 (run), each cycle where the selected tick is high either decrements the count or, when the count is 0, reloads it and sets raw bit i. The count reads the new value from the cycle after the tick.
- R5: With op=1 (hold), the count does not change whatever the tick inputs do.
- R6: Source code src selects the tick as follows:
  - 0: no tick
  - 1: `tick_ext`
  - 4 to 7: `tick_int[src-4]`
  - 2 and 3: no tick
- R7: Masked status is raw AND mask, and `irq` is high exactly when it is nonzero. A mask write takes effect on `irq` in the cycle after the write.
- R8: Writing the acknowledge location clears each raw bit whose written bit is 1. Written zero bits have no effect, and nothing of the written value is kept.
- R9: If an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R10: The time register increments by one for each cycle in which `time_tick` is high.
- R11: Writes to the count, time, raw status and masked status offsets have no effect.
- R12: `bus_err` is high in the access cycle of any access with `bus_be` other than 4'hF, and of any control write with op=3. Such accesses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Illegal access flag in the access cycle |
| tick_ext | input | 1 | External tick enable (source code 1) |
| tick_int | input | 4 | Internal tick enables (source codes 4 to 7) |
| time_tick | input | 1 | Increment enable for the time register |
| irq | output | 1 | Level interrupt, high while masked status is nonzero |

## Verification
A counter that decrements on the wrong tick source or in hold shows up in the count read back on the next access. A counter that reloads one tick early or late moves the raw status bit and `irq` by exactly one tick. Status logic that lets an acknowledge beat a same-cycle expiry shows as a raw bit reading 0 one cycle later, and that interrupt is then lost for good. A mask that is not applied at once is seen on `irq` in the cycle after the mask write.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  // control word layout: src in [4:2], op in [1:0]
  typedef struct packed {
    logic [2:0] src;
    tmr_op_e    op;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RST = '{src: 3'd0, op: OP_HOLD};

  // per-timer offsets inside a 16-byte slot
  localparam logic [3:0] OFS_RELOAD = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h4;
  localparam logic [3:0] OFS_CTRL   = 4'h8;

  // shared offsets
  localparam logic [ADDR_W-1:0] ADR_TIME   = 7'h38;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 7'h48;
  localparam logic [ADDR_W-1:0] ADR_ACK    = 7'h4C;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 7'h50;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 7'h54;

  // tick source decode: 1 external, 4..7 internal lanes, else none
  function automatic logic tick_pick(input logic [2:0] src,
                                     input logic       ext,
                                     input logic [3:0] lanes);
    logic t;
    t = 1'b0;
    if (src == 3'd1)
      t = ext;
    else if (src[2])
      t = lanes[src[1:0]];
    return t;
  endfunction

endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_wr,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wr_value,
  input  tmr_ctrl_t        ctrl_in,
  input  logic             tick_ext,
  input  logic [3:0]       tick_int,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output tmr_ctrl_t        ctrl_q,
  output logic             tick_en,
  output logic             expire
);

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - 1'b1;
  endfunction

  logic src_tick;

  always_comb begin
    src_tick = tick_pick(ctrl_q.src, tick_ext, tick_int);
    // a control write in the same cycle takes precedence over counting
    tick_en  = src_tick && (ctrl_q.op == OP_RUN) && !ctrl_wr;
    expire   = tick_en && (count_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= CTRL_RST;
    end else begin
      if (reload_wr)
        reload_q <= wr_value;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_in;
        if (ctrl_in.op == OP_LOAD)
          count_q <= reload_q;
      end else if (tick_en) begin
        count_q <= step_count(count_q, reload_q);
      end
    end
  end

endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic             ack_wr,
  input  logic [N_TMR-1:0] wr_bits,
  input  logic [N_TMR-1:0] expire,
  output logic [N_TMR-1:0] mask_q,
  output logic [N_TMR-1:0] raw_q,
  output logic [N_TMR-1:0] masked,
  output logic             irq
);

  // clear acknowledged bits first, then let fresh expiries set them again
  function automatic logic [N_TMR-1:0] raw_next(input logic [N_TMR-1:0] cur,
                                                input logic [N_TMR-1:0] clr,
                                                input logic [N_TMR-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [N_TMR-1:0] clr_bits;

  always_comb begin
    clr_bits = ack_wr ? wr_bits : '0;
    masked   = raw_q & mask_q;
    irq      = |masked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_next(raw_q, clr_bits, expire);
      if (mask_wr)
        mask_q <= wr_bits;
    end
  end

endmodule

// File: rtl/dtt_regbus.sv
module dtt_regbus
  import dtt_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [3:0]                   bus_be,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [N_TMR-1:0][CNT_W-1:0]  reload_q,
  input  logic [N_TMR-1:0][CNT_W-1:0]  count_q,
  input  tmr_ctrl_t [N_TMR-1:0]        ctrl_q,
  input  logic [TIME_W-1:0]            time_q,
  input  logic [N_TMR-1:0]             mask_q,
  input  logic [N_TMR-1:0]             raw_q,
  input  logic [N_TMR-1:0]             masked,
  output logic [N_TMR-1:0]             reload_wr,
  output logic [N_TMR-1:0]             ctrl_wr,
  output logic                         mask_wr,
  output logic                         ack_wr,
  output logic                         bus_err,
  output logic [DATA_W-1:0]            bus_rdata
);

  localparam int SLOT_W = ADDR_W - 4;

  logic             full_word;
  logic             wr_ok;
  logic             rd_ok;
  logic             bad_op;
  logic [N_TMR-1:0] slot_hit;
  logic [N_TMR-1:0] ctrl_hit;

  assign full_word = (bus_be == 4'hF);
  assign bad_op    = (tmr_op_e'(bus_wdata[1:0]) == OP_BAD);

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_slot
      assign slot_hit[gi]  = (bus_addr[ADDR_W-1:4] == SLOT_W'(gi));
      assign ctrl_hit[gi]  = slot_hit[gi] && (bus_addr[3:0] == OFS_CTRL);
      assign reload_wr[gi] = wr_ok && slot_hit[gi] && (bus_addr[3:0] == OFS_RELOAD);
      assign ctrl_wr[gi]   = wr_ok && ctrl_hit[gi] && !bad_op;
    end
  endgenerate

  always_comb begin
    wr_ok   = bus_sel && bus_wr && full_word;
    rd_ok   = bus_sel && !bus_wr && full_word;
    mask_wr = wr_ok && (bus_addr == ADR_MASK);
    ack_wr  = wr_ok && (bus_addr == ADR_ACK);
    bus_err = bus_sel && (!full_word || (bus_wr && (|ctrl_hit) && bad_op));
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (slot_hit[i]) begin
          case (bus_addr[3:0])
            OFS_RELOAD: bus_rdata = DATA_W'(reload_q[i]);
            OFS_COUNT:  bus_rdata = DATA_W'(count_q[i]);
            OFS_CTRL:   bus_rdata = DATA_W'(ctrl_q[i]);
            default:    bus_rdata = '0;
          endcase
        end
      end
      case (bus_addr)
        ADR_TIME:   bus_rdata = DATA_W'(time_q);
        ADR_MASK:   bus_rdata = DATA_W'(mask_q);
        ADR_RAW:    bus_rdata = DATA_W'(raw_q);
        ADR_MASKED: bus_rdata = DATA_W'(masked);
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              tick_ext,
  input  logic [3:0]        tick_int,
  input  logic              time_tick,
  output logic              irq
);

  logic [N_TMR-1:0][CNT_W-1:0] reload_q;
  logic [N_TMR-1:0][CNT_W-1:0] count_q;
  tmr_ctrl_t [N_TMR-1:0]       ctrl_q;
  logic [N_TMR-1:0]            reload_wr;
  logic [N_TMR-1:0]            ctrl_wr;
  logic [N_TMR-1:0]            tick_en;
  logic [N_TMR-1:0]            expire;
  logic [N_TMR-1:0]            mask_q;
  logic [N_TMR-1:0]            raw_q;
  logic [N_TMR-1:0]            masked;
  logic                        mask_wr;
  logic                        ack_wr;
  logic [TIME_W-1:0]           time_q;

  dtt_regbus #(.N_TMR(N_TMR), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_regbus (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .reload_q  (reload_q),
    .count_q   (count_q),
    .ctrl_q    (ctrl_q),
    .time_q    (time_q),
    .mask_q    (mask_q),
    .raw_q     (raw_q),
    .masked    (masked),
    .reload_wr (reload_wr),
    .ctrl_wr   (ctrl_wr),
    .mask_wr   (mask_wr),
    .ack_wr    (ack_wr),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
      dtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_wr (reload_wr[gi]),
        .ctrl_wr   (ctrl_wr[gi]),
        .wr_value  (bus_wdata[CNT_W-1:0]),
        .ctrl_in   (tmr_ctrl_t'(bus_wdata[4:0])),
        .tick_ext  (tick_ext),
        .tick_int  (tick_int),
        .count_q   (count_q[gi]),
        .reload_q  (reload_q[gi]),
        .ctrl_q    (ctrl_q[gi]),
        .tick_en   (tick_en[gi]),
        .expire    (expire[gi])
      );
    end
  endgenerate

  dtt_irq #(.N_TMR(N_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (mask_wr),
    .ack_wr  (ack_wr),
    .wr_bits (bus_wdata[N_TMR-1:0]),
    .expire  (expire),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .masked  (masked),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      time_q <= '0;
    else if (time_tick)
      time_q <= time_q + 1'b1;
  end

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dtt_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [3:0]                  bus_be,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        bus_err,
  input logic                        irq,
  input logic                        time_tick,
  input logic [TIME_W-1:0]           time_q,
  input logic [N_TMR-1:0]            expire,
  input logic [N_TMR-1:0]            ctrl_wr,
  input logic                        ack_wr,
  input logic                        mask_wr,
  input logic [N_TMR-1:0]            raw_q,
  input logic [N_TMR-1:0]            mask_q,
  input logic [N_TMR-1:0][CNT_W-1:0] count_q,
  input logic [N_TMR-1:0][CNT_W-1:0] reload_q,
  input tmr_ctrl_t [N_TMR-1:0]       ctrl_q
);

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_chk
      a_r4_reload_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire[gi] |=> count_q[gi] == $past(reload_q[gi]));
      a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire[gi] |=> raw_q[gi]);
      a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[gi] && !expire[gi]) |=> !raw_q[gi]);
      a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[gi].op != OP_RUN && !ctrl_wr[gi]) |=> $stable(count_q[gi]));
    end
  endgenerate

  a_r7_mask_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && ((bus_wdata[N_TMR-1:0] & raw_q) != '0)) |=> irq);

  a_r10_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    time_tick |=> time_q == $past(time_q) + 1'b1);

  a_r12_subword_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_be != 4'hF) |-> bus_err);

  a_r12_subword_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_be != 4'hF) |=> $stable(mask_q));

endmodule

bind dual_tick_timer dtt_checker #(.N_TMR(N_TMR), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .irq       (irq),
  .time_tick (time_tick),
  .time_q    (time_q),
  .expire    (expire),
  .ctrl_wr   (ctrl_wr),
  .ack_wr    (ack_wr),
  .mask_wr   (mask_wr),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .count_q   (count_q),
  .reload_q  (reload_q),
  .ctrl_q    (ctrl_q)
);

// File: tb/dual_tick_timer_test.sv
`timescale 1ns/1ps
module dual_tick_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        tick_ext = 1'b0;
  logic [3:0]  tick_int = '0;
  logic        time_tick = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic last_err;

  always #2 clk = ~clk;

  dual_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .tick_ext(tick_ext),
    .tick_int(tick_int), .time_tick(time_tick), .irq(irq)
  );

  // {wr, addr[6:0], data}: data is write value or expected read value
  localparam int NV = 15;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {1'b1, 7'h00, 32'd100},
    {1'b0, 7'h00, 32'd100},
    {1'b1, 7'h08, 32'h10},
    {1'b0, 7'h04, 32'd100},
    {1'b0, 7'h08, 32'h10},
    {1'b1, 7'h10, 32'd5},
    {1'b1, 7'h18, 32'h14},
    {1'b0, 7'h14, 32'd5},
    {1'b0, 7'h18, 32'h14},
    {1'b1, 7'h48, 32'd3},
    {1'b0, 7'h48, 32'd3},
    {1'b0, 7'h50, 32'd0},
    {1'b0, 7'h54, 32'd0},
    {1'b0, 7'h4C, 32'd0},
    {1'b0, 7'h20, 32'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    #1 last_err = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF; bus_wdata = '0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input logic [3:0] lanes, input logic ext, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_int = lanes; tick_ext = ext;
      @(negedge clk);
      tick_int = '0; tick_ext = 1'b0;
    end
  endtask

  task automatic check_irq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(7'h08, 32'h1, "R1 ctrl0");
    rd(7'h14, 32'h0, "R1 count1");
    rd(7'h48, 32'h0, "R1 mask");
    rd(7'h50, 32'h0, "R1 raw");
    rd(7'h38, 32'h0, "R1 time");
    check_irq("R1 irq", 1'b0);

    // R2 vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][39]) wr(VEC[v][38:32], VEC[v][31:0]);
      else            rd(VEC[v][38:32], VEC[v][31:0], "R2 vec");
    end

    // R4 run timer1 on lane 1 (src5), reload 5
    wr(7'h18, 32'h16);
    ticks(4'b0010, 1'b0, 3);
    rd(7'h14, 32'd2, "R4 count");
    ticks(4'b0010, 1'b0, 2);
    rd(7'h50, 32'd0, "R4 raw at zero");
    ticks(4'b0010, 1'b0, 1);
    rd(7'h14, 32'd5, "R4 reload");
    rd(7'h50, 32'd2, "R4 raw set");
    check_irq("R7 irq high", 1'b1);
    rd(7'h54, 32'd2, "R7 masked");

    // R8 acknowledge
    wr(7'h4C, 32'd0);
    rd(7'h50, 32'd2, "R8 zero ack");
    wr(7'h4C, 32'd2);
    rd(7'h50, 32'd0, "R8 ack clears");
    check_irq("R8 irq low", 1'b0);

    // R9 collision
    ticks(4'b0010, 1'b0, 5);
    @(negedge clk);
    tick_int = 4'b0010;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'd2;
    @(negedge clk);
    tick_int = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(7'h50, 32'd2, "R9 expiry wins");
    rd(7'h14, 32'd5, "R9 reloaded");
    wr(7'h4C, 32'd2);

    // R5 hold
    wr(7'h18, 32'h15);
    ticks(4'b1111, 1'b1, 3);
    rd(7'h14, 32'd5, "R5 hold");

    // R3 load
    wr(7'h18, 32'h16);
    ticks(4'b0010, 1'b0, 2);
    wr(7'h10, 32'd9);
    rd(7'h14, 32'd3, "R3 reload write alone");
    wr(7'h18, 32'h14);
    rd(7'h14, 32'd9, "R3 load copies");
    ticks(4'b0010, 1'b0, 2);
    rd(7'h14, 32'd9, "R3 stopped after load");

    // R6 source select on timer0 (count 100)
    wr(7'h08, 32'h12);
    ticks(4'b1110, 1'b1, 2);
    rd(7'h04, 32'd100, "R6 other lanes");
    ticks(4'b0001, 1'b0, 2);
    rd(7'h04, 32'd98, "R6 lane0");
    wr(7'h08, 32'h02);
    ticks(4'b1111, 1'b1, 2);
    rd(7'h04, 32'd98, "R6 src0 none");
    wr(7'h08, 32'h06);
    ticks(4'b0000, 1'b1, 3);
    rd(7'h04, 32'd95, "R6 external");
    wr(7'h08, 32'h1E);
    ticks(4'b1000, 1'b0, 1);
    rd(7'h04, 32'd94, "R6 lane3");
    wr(7'h08, 32'h0A);
    ticks(4'b1111, 1'b1, 2);
    rd(7'h04, 32'd94, "R6 src2 none");

    // R7 mask
    wr(7'h48, 32'd0);
    wr(7'h18, 32'h16);
    ticks(4'b0010, 1'b0, 10);
    wr(7'h18, 32'h15);
    rd(7'h50, 32'd2, "R7 raw");
    check_irq("R7 masked off", 1'b0);
    rd(7'h54, 32'd0, "R7 masked zero");
    wr(7'h48, 32'd2);
    check_irq("R7 mask on", 1'b1);
    rd(7'h54, 32'd2, "R7 masked two");
    wr(7'h48, 32'd1);
    check_irq("R7 mask other", 1'b0);

    // R12 illegal accesses
    wr(7'h48, 32'd2, 4'b0011);
    check("R12 subword err", {31'd0, last_err}, 32'd1);
    rd(7'h48, 32'd1, "R12 mask kept");
    wr(7'h18, 32'h17);
    check("R12 bad op err", {31'd0, last_err}, 32'd1);
    rd(7'h18, 32'h15, "R12 ctrl kept");
    wr(7'h10, 32'd9);
    check("R12 legal no err", {31'd0, last_err}, 32'd0);

    // R10 time
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); time_tick = 1'b1;
      @(negedge clk); time_tick = 1'b0;
    end
    rd(7'h38, 32'd3, "R10 time");

    // R11 read-only offsets
    wr(7'h38, 32'h55);
    rd(7'h38, 32'd3, "R11 time");
    wr(7'h50, 32'd0);
    rd(7'h50, 32'd2, "R11 raw");
    wr(7'h54, 32'd0);
    rd(7'h54, 32'd0, "R11 masked");
    wr(7'h04, 32'h77);
    rd(7'h04, 32'd94, "R11 count");

    // R1 reset again with irq asserted
    wr(7'h48, 32'd2);
    check_irq("R1 pre-reset irq", 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_irq("R1 irq after reset", 1'b0);
    rd(7'h50, 32'd0, "R1 raw after reset");
    rd(7'h48, 32'd0, "R1 mask after reset");
    rd(7'h18, 32'h1, "R1 ctrl after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule